// File: doc/BRIEF.md
# Text-Mode Raster Pixel Generator

This block drives a 640x480 raster at a 25.175 MHz pixel clock. The screen shows 80 columns by 30 rows of text. Each cell is 8 pixels wide and 16 lines tall, and each pixel carries a 4-bit colour with an intensity bit. The block keeps a horizontal position count and a vertical line count. From these it decodes active-low horizontal and vertical sync. It also forms the read address for the character and attribute buffers, and the glyph-memory address for the current character. The buffers themselves live outside the block and answer combinationally in the same cycle.

The glyph memory is slow. For that reason the block fetches each cell one cell ahead of the beam. The glyph row and the attribute byte are captured on the last pixel clock of the current cell. The captured cell is then shifted out one pixel per clock across the following eight clocks. Every pixel therefore leaves the block exactly eight clocks after its counter position. Horizontal sync, vertical sync and the visible-window flag pass through a matching eight-stage delay so that they stay aligned with the pixels.

All timings are parameters. The defaults are an 800-clock line (640 visible, 16 front porch, 96 sync, 48 back porch) and a 525-line frame (480 visible, 10 front porch, 2 sync, 33 back porch).

Top module: `vga_text_pixel_gen`

## Requirements
- R1: The position count runs 0..799 and then returns to 0. The line count steps by one each time the position count returns to 0, and runs 0..524 before it returns to 0.
- R2: The reset input is asynchronous and active low. While it is low, hsync_n and vsync_n are 1, irgb is 0 and vram_addr is 0. The counts stay at 0 for two rising clock edges after the reset input goes high, and start to advance on the third edge.
- R3: hsync_n is 0 exactly while the position count is 664..759, which is positions 656..751 delayed by 8 clocks. It is 1 at every other position.
- R4: vsync_n is 0 from the clock on which hsync_n falls on line 490 up to the clock on which hsync_n falls on line 492. It changes only on a clock on which hsync_n falls.
- R5: vram_addr = {line[8:4], position[9:3]}, taken from the current, undelayed counts. Bits 11:7 are the text row and bits 6:0 are the text column.
- R6: font_addr = {char_code, line[3:0]}. This is a combinational function of the char_code input and the current line.
- R7: For the visible pixel at position p and line l, irgb shows a value eight clocks later. It shows color_byte[7:4] if bit (7 - p mod 8) of the glyph row is 1, and color_byte[3:0] if that bit is 0. Bit 7 is therefore the leftmost pixel.
- R8: irgb is 0 whenever the delayed pixel lies outside positions 0..639 or lines 0..479.
- R9: font_row and color_byte are sampled only in the last clock of each cell, when position mod 8 = 7. Their values in the other seven clocks have no effect on irgb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| vram_addr | output | 12 | Character and attribute buffer read index |
| char_code | input | 8 | Character code read at vram_addr |
| color_byte | input | 8 | Attribute byte read at vram_addr: foreground in bits 7:4, background in bits 3:0 |
| font_addr | output | 12 | Glyph memory address |
| font_row | input | 8 | Glyph row read at font_addr, bit 7 leftmost |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| irgb | output | 4 | Pixel colour {I,R,G,B} |

## Verification
The bench targets the alignment between the pixel path and the sync path. A design whose sync delay is one stage longer or shorter than the pixel delay shifts hsync against the image. A design that updates vsync at the line wrap instead of at the sync pulse makes vsync change on a clock where hsync does not fall. The bench corrupts font_row and color_byte in every clock except the last of each cell. A design that samples them at the wrong moment then shows corrupted colours. The bench also checks the pixel bit order, the choice between foreground and background, the frame wrap, and an asynchronous reset taken in the middle of a line. A reversed glyph, swapped nibbles, or a frame that runs one line too long all produce pixel or address mismatches.

// File: rtl/vga_text_pkg.sv
package vga_text_pkg;
  // Flags that travel with the pixel through the output delay.
  typedef struct packed {
    logic hs_act;  // horizontal sync pulse active
    logic vs_act;  // vertical sync pulse active
    logic vis;     // inside visible window
  } sync_bits_t;

  localparam int SYNC_BITS_W = $bits(sync_bits_t);
endpackage

// File: rtl/vga_scan_counter.sv
module vga_scan_counter #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int COL_W   = 10,
  parameter int ROW_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);
  logic             col_end, row_end;
  logic [COL_W-1:0] col_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    col_end = (col == COL_W'(H_TOTAL - 1));
    row_end = (row == ROW_W'(V_TOTAL - 1));
    col_d   = col_end ? '0 : col + 1'b1;
    row_d   = row;
    if (col_end) row_d = row_end ? '0 : row + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else begin
      col <= col_d;
      row <= row_d;
    end
  end
endmodule

// File: rtl/vga_sync_decode.sv
module vga_sync_decode
  import vga_text_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int HS_START = 656,
  parameter int HS_END   = 752,
  parameter int V_ACTIVE = 480,
  parameter int VS_START = 490,
  parameter int VS_END   = 492,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output sync_bits_t       flags
);
  logic vs_q, vs_d, vs_arm, vs_hit;

  always_comb begin
    // Vertical state is re-evaluated once per line, just before the
    // horizontal pulse begins, so both flags change together.
    vs_arm = (col == COL_W'(HS_START - 1));
    vs_hit = (row >= ROW_W'(VS_START)) && (row < ROW_W'(VS_END));
    vs_d   = vs_arm ? vs_hit : vs_q;

    flags.hs_act = (col >= COL_W'(HS_START)) && (col < COL_W'(HS_END));
    flags.vs_act = vs_q;
    flags.vis    = (col < COL_W'(H_ACTIVE)) && (row < ROW_W'(V_ACTIVE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vs_d;
  end
endmodule

// File: rtl/vga_delay_line.sv
module vga_delay_line #(
  parameter int W     = 3,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] d;
    if (i == 0) begin : g_head
      assign d = din;
    end else begin : g_tail
      assign d = g_stage[i-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign dout = g_stage[DEPTH-1].q;
endmodule

// File: rtl/vga_cell_fetch.sv
module vga_cell_fetch #(
  parameter int CELL_W = 8,
  parameter int IRGB_W = 4,
  localparam int CW_BITS = $clog2(CELL_W),
  localparam int ATTR_W  = 2 * IRGB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_BITS-1:0] px,
  input  logic [CELL_W-1:0] font_row,
  input  logic [ATTR_W-1:0] color_byte,
  output logic [CELL_W-1:0] font_q,
  output logic [IRGB_W-1:0] pix
);
  logic              load, bit_on;
  logic [CELL_W-1:0] font_d;
  logic [ATTR_W-1:0] color_q, color_d;

  always_comb begin
    // Capture the next cell in the final clock of the current one.
    load    = (px == CW_BITS'(CELL_W - 1));
    font_d  = load ? font_row   : font_q;
    color_d = load ? color_byte : color_q;
    bit_on  = font_q[CW_BITS'(CELL_W - 1) - px];
    pix     = bit_on ? color_q[ATTR_W-1:IRGB_W] : color_q[IRGB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      font_q  <= '0;
      color_q <= '0;
    end else begin
      font_q  <= font_d;
      color_q <= color_d;
    end
  end
endmodule

// File: rtl/vga_text_pixel_gen.sv
module vga_text_pixel_gen
  import vga_text_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 10,
  parameter int CELL_W   = 8,
  parameter int CELL_H   = 16,
  parameter int CHAR_W   = 8,
  parameter int IRGB_W   = 4,
  localparam int CW_BITS  = $clog2(CELL_W),
  localparam int CH_BITS  = $clog2(CELL_H),
  localparam int RFLD_W   = ROW_W - 1 - CH_BITS,
  localparam int CFLD_W   = COL_W - CW_BITS,
  localparam int ADDR_W   = RFLD_W + CFLD_W,
  localparam int FADDR_W  = CHAR_W + CH_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [ADDR_W-1:0]  vram_addr,
  input  logic [CHAR_W-1:0]  char_code,
  input  logic [2*IRGB_W-1:0] color_byte,
  output logic [FADDR_W-1:0] font_addr,
  input  logic [CELL_W-1:0]  font_row,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic [IRGB_W-1:0]  irgb
);
  localparam int H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HS_START = H_ACTIVE + H_FRONT;
  localparam int VS_START = V_ACTIVE + V_FRONT;

  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  sync_bits_t        flags_raw, flags_dly;
  logic [SYNC_BITS_W-1:0] dly_vec;
  logic [CELL_W-1:0] font_q;
  logic [IRGB_W-1:0] pix_raw;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  vga_scan_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
                     .COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .col(col), .row(row));

  vga_sync_decode #(.H_ACTIVE(H_ACTIVE), .HS_START(HS_START),
                    .HS_END(HS_START + H_SYNC), .V_ACTIVE(V_ACTIVE),
                    .VS_START(VS_START), .VS_END(VS_START + V_SYNC),
                    .COL_W(COL_W), .ROW_W(ROW_W)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .col(col), .row(row), .flags(flags_raw));

  vga_delay_line #(.W(SYNC_BITS_W), .DEPTH(CELL_W)) u_dly (
    .clk(clk), .rst_n(rst_q_n), .din(flags_raw), .dout(dly_vec));
  assign flags_dly = dly_vec;

  vga_cell_fetch #(.CELL_W(CELL_W), .IRGB_W(IRGB_W)) u_fetch (
    .clk(clk), .rst_n(rst_q_n), .px(col[CW_BITS-1:0]),
    .font_row(font_row), .color_byte(color_byte),
    .font_q(font_q), .pix(pix_raw));

  always_comb begin
    vram_addr = {row[ROW_W-2:CH_BITS], col[COL_W-1:CW_BITS]};
    font_addr = {char_code, row[CH_BITS-1:0]};
    hsync_n   = ~flags_dly.hs_act;
    vsync_n   = ~flags_dly.vs_act;
    irgb      = flags_dly.vis ? pix_raw : '0;
  end
endmodule

// File: rtl/vga_text_pixel_gen_chk.sv
module vga_text_pixel_gen_chk #(
  parameter int H_TOTAL  = 800,
  parameter int HS_START = 656,
  parameter int HS_END   = 752,
  parameter int V_TOTAL  = 525,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 10,
  parameter int CELL_W   = 8,
  parameter int IRGB_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [COL_W-1:0]  col,
  input logic [ROW_W-1:0]  row,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic [IRGB_W-1:0] irgb,
  input logic [CELL_W-1:0] font_q
);
  localparam int CW_BITS = $clog2(CELL_W);

  p_col_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_W'(H_TOTAL - 1));

  p_col_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (col == COL_W'(H_TOTAL - 1)) |=> (col == '0));

  p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (col == COL_W'(H_TOTAL - 1) && row != ROW_W'(V_TOTAL - 1))
      |=> (row == $past(row) + 1'b1));

  p_row_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (col != COL_W'(H_TOTAL - 1)) |=> $stable(row));

  p_hs_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col >= COL_W'(HS_START + CELL_W) && col < COL_W'(HS_END + CELL_W))
      |-> !hsync_n);

  p_hs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col < COL_W'(HS_START + CELL_W) || col >= COL_W'(HS_END + CELL_W))
      |-> hsync_n);

  p_vs_on_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_n) |-> $fell(hsync_n));

  p_line_head_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (col < COL_W'(CELL_W)) |-> (irgb == '0));

  p_glyph_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col[CW_BITS-1:0] != '0) |-> $stable(font_q));
endmodule

bind vga_text_pixel_gen vga_text_pixel_gen_chk #(
  .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_END(HS_START + H_SYNC),
  .V_TOTAL(V_TOTAL), .COL_W(COL_W), .ROW_W(ROW_W),
  .CELL_W(CELL_W), .IRGB_W(IRGB_W)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .col(col), .row(row),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .irgb(irgb), .font_q(font_q)
);

// File: tb/tb_vga_text_pixel_gen.sv
module tb_vga_text_pixel_gen;
  localparam int CLK_P  = 40;
  localparam int H_T    = 800;
  localparam int V_ACT  = 32;
  localparam int V_FP   = 2;
  localparam int V_SY   = 2;
  localparam int V_BP   = 3;
  localparam int V_T    = V_ACT + V_FP + V_SY + V_BP;
  localparam int VS0    = V_ACT + V_FP;
  localparam int HS0    = 656;
  localparam int HS1    = 752;
  localparam int DLY    = 8;

  logic        clk, rst_n;
  logic [11:0] vram_addr, font_addr;
  logic [7:0]  char_code, color_byte, font_row;
  logic        hsync_n, vsync_n;
  logic [3:0]  irgb;

  int n_checks = 0;
  int n_fail   = 0;
  int n_pos    = 0;
  bit scramble = 0;
  bit done     = 0;

  vga_text_pixel_gen #(.V_ACTIVE(V_ACT), .V_FRONT(V_FP), .V_SYNC(V_SY),
                       .V_BACK(V_BP)) dut (
    .clk(clk), .rst_n(rst_n), .vram_addr(vram_addr), .char_code(char_code),
    .color_byte(color_byte), .font_addr(font_addr), .font_row(font_row),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .irgb(irgb));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Behavioural buffer contents, computed rather than stored.
  function automatic logic [7:0] char_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]};
  endfunction
  function automatic logic [7:0] font_fn(input logic [11:0] fa);
    return fa[11:4] ^ {fa[3:0], fa[3:0]} ^ 8'hA5;
  endfunction
  function automatic logic [7:0] color_fn(input logic [11:0] a);
    return {a[3:0] ^ 4'h9, a[9:6] ^ a[3:0]};
  endfunction
  function automatic logic [11:0] addr_of(input int c, input int r);
    return {5'(r / 16), 7'(c / 8)};
  endfunction

  always_comb begin
    char_code  = char_fn(vram_addr);
    font_row   = font_fn(font_addr);
    color_byte = color_fn(vram_addr);
    if (scramble && ((n_pos % H_T) % 8) != 7) begin
      font_row   = ~font_row;
      color_byte = ~color_byte;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at pos %0d: actual=%0h expected=%0h",
               req, what, n_pos, act, exp);
    end
  endtask

  // Expected outputs eight clocks after a position, from the requirements.
  task automatic model(input int nn, output logic e_hs, output logic e_vs,
                       output logic [3:0] e_px, output bit e_vis);
    int src, cs, rs, m, vr;
    logic [11:0] a;
    logic [7:0]  ch, fr, cb;
    src = nn - DLY;
    e_hs = 1'b1; e_vs = 1'b1; e_px = 4'h0; e_vis = 1'b0;
    if (src >= 0) begin
      cs = src % H_T;
      rs = (src / H_T) % V_T;
      e_hs = !(cs >= HS0 && cs < HS1);
      m = src - HS0;
      if (m >= 0) begin
        vr = (m / H_T) % V_T;
        e_vs = !(vr >= VS0 && vr < VS0 + V_SY);
      end
      if (cs < 640 && rs < V_ACT) begin
        e_vis = 1'b1;
        a  = addr_of(cs, rs);
        ch = char_fn(a);
        fr = font_fn({ch, 4'(rs)});
        cb = color_fn(a);
        e_px = fr[7 - (cs % 8)] ? cb[7:4] : cb[3:0];
      end
    end
  endtask

  task automatic cmp_now(input string pix_req);
    logic e_hs, e_vs, e_vis;
    logic [3:0] e_px;
    logic [11:0] e_a;
    int c, r;
    c = n_pos % H_T;
    r = (n_pos / H_T) % V_T;
    e_a = addr_of(c, r);
    model(n_pos, e_hs, e_vs, e_px, e_vis);
    chk(vram_addr == e_a, "R5", "vram_addr", int'(vram_addr), int'(e_a));
    chk(font_addr == {char_fn(e_a), 4'(r)}, "R6", "font_addr",
        int'(font_addr), int'({char_fn(e_a), 4'(r)}));
    chk(hsync_n == e_hs, "R3", "hsync_n", int'(hsync_n), int'(e_hs));
    chk(vsync_n == e_vs, "R4", "vsync_n", int'(vsync_n), int'(e_vs));
    chk(irgb == e_px, e_vis ? pix_req : "R8", "irgb", int'(irgb), int'(e_px));
  endtask

  task automatic step(input string pix_req);
    @(posedge clk);
    @(negedge clk);
    n_pos++;
    cmp_now(pix_req);
  endtask

  task automatic check_reset_outputs(input string what);
    chk(hsync_n == 1'b1, "R2", {what, " hsync_n"}, int'(hsync_n), 1);
    chk(vsync_n == 1'b1, "R2", {what, " vsync_n"}, int'(vsync_n), 1);
    chk(irgb == 4'h0, "R2", {what, " irgb"}, int'(irgb), 0);
    chk(vram_addr == 12'h0, "R2", {what, " vram_addr"}, int'(vram_addr), 0);
  endtask

  // Release reset and confirm the counts hold for two edges (R2).
  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      check_reset_outputs("release hold");
    end
    n_pos = 0;
    cmp_now("R7");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check_reset_outputs("in reset");
    release_reset();
  endtask

  // Opening lines: pixels, hsync, addresses (R3, R5, R6, R7, R8).
  task automatic t_first_lines();
    repeat (2 * H_T + 100) step("R7");
  endtask

  // Glyph and attribute inputs corrupted outside the capture clock (R9).
  task automatic t_capture();
    scramble = 1'b1;
    repeat (2 * H_T) step("R9");
    scramble = 1'b0;
  endtask

  // Through vsync and the frame wrap (R1, R4).
  task automatic t_frame();
    while (n_pos < V_T * H_T + H_T + 200) begin
      step("R7");
      if (n_pos == V_T * H_T)
        chk(vram_addr == 12'h0, "R1", "frame wrap address",
            int'(vram_addr), 0);
      if (n_pos == V_T * H_T - 1)
        chk(vram_addr == addr_of(H_T - 1, V_T - 1), "R1", "last position",
            int'(vram_addr), int'(addr_of(H_T - 1, V_T - 1)));
    end
  endtask

  // Asynchronous reset in the middle of a visible line (R2).
  task automatic t_midreset();
    while ((n_pos % H_T) != 300) step("R7");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_outputs("async assert");
    release_reset();
    repeat (H_T + 100) step("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1..: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_first_lines();
    t_capture();
    t_frame();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule